// File: doc/BRIEF.md
# Debug Probe Control and Sticky Status Register

This block is the control and status register of a debug probe. It drives the probe's target-side control lines: system reset, test reset, target power switch, two indicator LEDs and the selection between adaptive return-clock mode and fixed-divider clocking. It also gathers three event flags from the target side: a sensed system reset, a target power dropout and a return-clock timeout. Each event input passes through a two-flop synchroniser and is caught in a sticky flag.

Software never reads, modifies and writes this register. It writes ones to a set port to raise control bits and ones to a clear port to lower them. Zero bits leave the state alone. The two event flags that track a level are re-armed through the set port. A write of one to such a flag bit throws away its history and loads the present synchronised level. The return-clock timeout flag is cleared through the clear port. Both ports return the same combined read view.

Top module: `dbgcs_top`

## Requirements
- R1: After reset, test reset and system reset are low, power-off is high (target unpowered), both LEDs and return-clock mode are low, all flags are zero, and the read view is 0x008.
- R2: A write to the set port (word 4) raises every control bit written as one and leaves bits written as zero unchanged.
- R3: A write to the clear port (word 5) lowers every control bit written as one and leaves bits written as zero unchanged.
- R4: The control bit positions are: bit 0 system reset, bit 1 test reset, bit 3 power-off, bits 4 and 5 the LEDs, and bit 8 return-clock mode. Each output follows its bit in the cycle after the write. Bits 2, 9 and 11 to 31 are not stored, have no effect on either port, and read as zero.
- R5: Each event input is synchronised by two flops. A level held for three clock edges is caught in its flag. The flag then stays set after the input falls.
- R6: The sensed-reset flag is bit 6. A write of one to bit 6 of the set port loads that flag with the present synchronised level. Bit 6 at the clear port has no effect.
- R7: The power-dropout flag is bit 7. A write of one to bit 7 of the set port loads that flag with the present synchronised level.
- R8: The return-clock timeout flag is bit 10. It stays set until a one is written to bit 10 of the clear port, and bit 10 at the set port has no effect. If the synchronised timeout is still active during that clear, the flag stays set.
- R9: Both port words return the same read view. Any other word reads as zero, and writes to other words change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read view for the addressed word |
| sense_srst | input | 1 | Asynchronous sensed system reset, active high |
| sense_pwr_drop | input | 1 | Asynchronous power dropout indication, active high |
| sense_rclk_tmo | input | 1 | Asynchronous return-clock timeout event, active high |
| srst_o | output | 1 | System reset drive, active high |
| trst_o | output | 1 | Test reset drive, active high |
| pwr_off_o | output | 1 | Target power off when high |
| led_o | output | 2 | Indicator LEDs |
| rclk_mode_o | output | 1 | Adaptive return-clock mode when high |

## Verification
The assertions assume that each write strobe lasts one cycle, and that the address and data are steady while it is high. They also assume that flags fall only through their own re-arm or clear action, so any other fall is reported as a fault. The stimulus changes the bus only one time unit after a rising edge. It holds each event input for at least one full cycle, so the synchroniser samples it. Reads are taken only after the event has had time to cross the two synchroniser flops and the flag register.

// File: rtl/dbgcs_pkg.sv
package dbgcs_pkg;

  localparam int unsigned BIT_SRST   = 0;
  localparam int unsigned BIT_TRST   = 1;
  localparam int unsigned BIT_PWROFF = 3;
  localparam int unsigned BIT_LED0   = 4;
  localparam int unsigned BIT_LED1   = 5;
  localparam int unsigned BIT_FSRST  = 6;
  localparam int unsigned BIT_FDROP  = 7;
  localparam int unsigned BIT_RCLK   = 8;
  localparam int unsigned BIT_FTMO   = 10;
  localparam int unsigned NUM_FLAGS  = 3;

  typedef enum logic [0:0] {
    FLAG_REARM_ON_SET  = 1'b0,
    FLAG_CLEAR_ON_CLR  = 1'b1
  } flag_kind_e;

  function automatic int unsigned flag_pos(input int unsigned idx);
    case (idx)
      0:       return BIT_FSRST;
      1:       return BIT_FDROP;
      default: return BIT_FTMO;
    endcase
  endfunction

  function automatic flag_kind_e flag_kind(input int unsigned idx);
    return (idx == 2) ? FLAG_CLEAR_ON_CLR : FLAG_REARM_ON_SET;
  endfunction

endpackage

// File: rtl/dbgcs_sync.sv
module dbgcs_sync #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/dbgcs_ctl.sv
module dbgcs_ctl #(
  parameter int unsigned       DATA_W  = 32,
  parameter logic [DATA_W-1:0] MASK    = '0,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctl_o
);
  logic [DATA_W-1:0] ctl_q;
  logic [DATA_W-1:0] ctl_d;
  logic              ctl_en;
  logic [DATA_W-1:0] set_bits;
  logic [DATA_W-1:0] clr_bits;

  always_comb begin
    set_bits = set_we ? (wdata & MASK) : '0;
    clr_bits = clr_we ? (wdata & MASK) : '0;
    ctl_en   = set_we | clr_we;
    ctl_d    = (ctl_q | set_bits) & ~clr_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= RST_VAL;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/dbgcs_flag.sv
module dbgcs_flag #(
  parameter dbgcs_pkg::flag_kind_e KIND = dbgcs_pkg::FLAG_REARM_ON_SET
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sense,
  input  logic set_we,
  input  logic clr_we,
  input  logic cmd,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;
  logic action;

  always_comb begin
    action = (KIND == dbgcs_pkg::FLAG_CLEAR_ON_CLR) ? (clr_we & cmd) : (set_we & cmd);
    flag_d = action ? sense : (flag_q | sense);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/dbgcs_top.sv
module dbgcs_top #(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned SET_WORD = 4,
  parameter int unsigned CLR_WORD = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sense_srst,
  input  logic              sense_pwr_drop,
  input  logic              sense_rclk_tmo,
  output logic              srst_o,
  output logic              trst_o,
  output logic              pwr_off_o,
  output logic [1:0]        led_o,
  output logic              rclk_mode_o
);
  import dbgcs_pkg::*;

  localparam int unsigned NF = NUM_FLAGS;
  localparam logic [DATA_W-1:0] CTL_MASK =
    (DATA_W'(1) << BIT_SRST) | (DATA_W'(1) << BIT_TRST) | (DATA_W'(1) << BIT_PWROFF) |
    (DATA_W'(1) << BIT_LED0) | (DATA_W'(1) << BIT_LED1) | (DATA_W'(1) << BIT_RCLK);
  localparam logic [DATA_W-1:0] CTL_RST = DATA_W'(1) << BIT_PWROFF;

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic              set_hit;
  logic              clr_hit;
  logic              set_we;
  logic              clr_we;
  logic [DATA_W-1:0] ctl_q;
  logic [NF-1:0]     sense_sync;
  logic [NF-1:0]     flag_q;
  logic [DATA_W-1:0] view;

  // Reset: asserted at once, released after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  always_comb begin
    set_hit = (bus_addr == ADDR_W'(SET_WORD));
    clr_hit = (bus_addr == ADDR_W'(CLR_WORD));
    set_we  = bus_wr & set_hit;
    clr_we  = bus_wr & clr_hit;
  end

  dbgcs_ctl #(
    .DATA_W  (DATA_W),
    .MASK    (CTL_MASK),
    .RST_VAL (CTL_RST)
  ) u_ctl (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_we (set_we),
    .clr_we (clr_we),
    .wdata  (bus_wdata),
    .ctl_o  (ctl_q)
  );

  dbgcs_sync #(.WIDTH(NF)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .async_i ({sense_rclk_tmo, sense_pwr_drop, sense_srst}),
    .sync_o  (sense_sync)
  );

  for (genvar i = 0; i < NF; i++) begin : g_flag
    dbgcs_flag #(.KIND(flag_kind(i))) u_flag (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .sense  (sense_sync[i]),
      .set_we (set_we),
      .clr_we (clr_we),
      .cmd    (bus_wdata[flag_pos(i)]),
      .flag_o (flag_q[i])
    );
  end

  always_comb begin
    view = ctl_q;
    for (int i = 0; i < NF; i++) view[flag_pos(i)] = flag_q[i];
    bus_rdata = (set_hit | clr_hit) ? view : '0;
  end

  assign srst_o      = ctl_q[BIT_SRST];
  assign trst_o      = ctl_q[BIT_TRST];
  assign pwr_off_o   = ctl_q[BIT_PWROFF];
  assign led_o       = {ctl_q[BIT_LED1], ctl_q[BIT_LED0]};
  assign rclk_mode_o = ctl_q[BIT_RCLK];
endmodule

// File: rtl/dbgcs_chk.sv
module dbgcs_chk #(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned SET_WORD = 4,
  parameter int unsigned CLR_WORD = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              srst_o,
  input logic              trst_o,
  input logic              pwr_off_o,
  input logic [1:0]        led_o,
  input logic              rclk_mode_o,
  input logic [2:0]        flag_q
);
  logic wr_set;
  logic wr_clr;
  assign wr_set = bus_wr && (bus_addr == ADDR_W'(SET_WORD));
  assign wr_clr = bus_wr && (bus_addr == ADDR_W'(CLR_WORD));

  assert_set_srst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set && bus_wdata[0]) |=> srst_o);

  assert_clr_trst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && bus_wdata[1]) |=> !trst_o);

  assert_hold_outputs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set || wr_clr) |=> $stable({srst_o, trst_o, pwr_off_o, led_o, rclk_mode_o}));

  assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[2] == 1'b0) && (bus_rdata[9] == 1'b0) && (bus_rdata[DATA_W-1:11] == '0));

  assert_srst_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q[0]) |-> $past(wr_set && bus_wdata[6]));

  assert_drop_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q[1]) |-> $past(wr_set && bus_wdata[7]));

  assert_tmo_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q[2]) |-> $past(wr_clr && bus_wdata[10]));
endmodule

bind dbgcs_top dbgcs_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .SET_WORD (SET_WORD),
  .CLR_WORD (CLR_WORD)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .srst_o      (srst_o),
  .trst_o      (trst_o),
  .pwr_off_o   (pwr_off_o),
  .led_o       (led_o),
  .rclk_mode_o (rclk_mode_o),
  .flag_q      (flag_q)
);

// File: tb/sim_dbgcs_top.sv
module sim_dbgcs_top;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam logic [AW-1:0] A_SET = 6'd4;
  localparam logic [AW-1:0] A_CLR = 6'd5;
  localparam logic [AW-1:0] A_OTH = 6'd0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          sense_srst = 1'b0;
  logic          sense_pwr_drop = 1'b0;
  logic          sense_rclk_tmo = 1'b0;
  logic          srst_o, trst_o, pwr_off_o, rclk_mode_o;
  logic [1:0]    led_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic chk_req = 1'b0;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  bit            pin_q[$];

  always #5 clk = ~clk;

  dbgcs_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sense_srst(sense_srst),
    .sense_pwr_drop(sense_pwr_drop), .sense_rclk_tmo(sense_rclk_tmo),
    .srst_o(srst_o), .trst_o(trst_o), .pwr_off_o(pwr_off_o), .led_o(led_o),
    .rclk_mode_o(rclk_mode_o)
  );

  // Monitor: pops an expected item and compares it against the ports.
  always @(negedge clk) begin
    if (chk_req && exp_q.size() > 0) begin
      logic [DW-1:0] e;
      string t;
      bit p;
      logic [5:0] pins_act, pins_exp;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      p = pin_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: rdata actual 0x%08h expected 0x%08h", t, bus_rdata, e);
      end
      if (p) begin
        pins_act = {rclk_mode_o, led_o[1], led_o[0], pwr_off_o, trst_o, srst_o};
        pins_exp = {e[8], e[5], e[4], e[3], e[1], e[0]};
        checks++;
        if (pins_act !== pins_exp) begin
          errors++;
          $display("FAIL %s: pins actual %06b expected %06b", t, pins_act, pins_exp);
        end
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string t);
    @(posedge clk); #1;
    bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t); pin_q.push_back(a == A_SET || a == A_CLR);
    chk_req = 1'b1;
    @(posedge clk); #1;
    chk_req = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    rd(A_SET, 32'h008, "R1 reset view");
    wr(A_SET, 32'h30);        rd(A_SET, 32'h038, "R2 leds set");
    wr(A_CLR, 32'h08);        rd(A_CLR, 32'h030, "R3 power on");
    wr(A_SET, 32'h103);       rd(A_SET, 32'h133, "R4 resets and rclk");
    wr(A_CLR, 32'h011);       rd(A_SET, 32'h122, "R3 partial clear");
    wr(A_SET, 32'hFFFF_F204); rd(A_SET, 32'h122, "R4 unused bits ignored");
    wr(A_OTH, 32'hFFFF_FFFF); rd(A_CLR, 32'h122, "R9 other word write ignored");
    rd(A_OTH, 32'h0, "R9 other word reads zero");

    sense_srst = 1'b1; settle(); rd(A_SET, 32'h162, "R5 srst caught");
    sense_srst = 1'b0; settle(); rd(A_SET, 32'h162, "R5 srst sticky");
    wr(A_CLR, 32'h040);       rd(A_SET, 32'h162, "R6 clear port no effect");
    wr(A_SET, 32'h040);       rd(A_SET, 32'h122, "R6 rearm low");
    sense_srst = 1'b1; settle();
    wr(A_SET, 32'h040);       rd(A_SET, 32'h162, "R6 rearm high");
    sense_srst = 1'b0; settle();
    wr(A_SET, 32'h040);       rd(A_CLR, 32'h122, "R6 rearm after fall");

    sense_pwr_drop = 1'b1; settle(); sense_pwr_drop = 1'b0; settle();
    rd(A_SET, 32'h1A2, "R7 dropout sticky");
    wr(A_SET, 32'h080);       rd(A_SET, 32'h122, "R7 dropout rearm");

    @(posedge clk); #1 sense_rclk_tmo = 1'b1;
    @(posedge clk); #1 sense_rclk_tmo = 1'b0;
    settle();                 rd(A_SET, 32'h522, "R8 timeout pulse caught");
    wr(A_SET, 32'h400);       rd(A_SET, 32'h522, "R8 set port no effect");
    wr(A_CLR, 32'h400);       rd(A_SET, 32'h122, "R8 cleared");
    sense_rclk_tmo = 1'b1; settle();
    wr(A_CLR, 32'h400);       rd(A_SET, 32'h522, "R8 clear while active keeps");
    sense_rclk_tmo = 1'b0; settle();
    wr(A_CLR, 32'h400);       rd(A_SET, 32'h122, "R8 cleared after fall");

    wr(A_CLR, 32'hFFFF_FFFF); rd(A_CLR, 32'h000, "R3 clear all");
    wr(A_SET, 32'h008);       rd(A_SET, 32'h008, "R2 power off again");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule